// File: doc/BRIEF.md
# Coincidence-Counting Binary Synapse Array

This block holds a row of binary synapses. Each synapse keeps a one-bit weight, with 0 standing for low conductance and 1 for high conductance, and a small count of coincidences. A coincidence is a presynaptic spike and a postsynaptic spike seen at the same synapse in the same timestep. Once a synapse has gathered as many coincidences as the programmed sensitivity, its weight inverts and its count restarts from zero. The rule does not depend on spike order or on the present weight, so the weight oscillates between its two states at a rate set by coincidence activity.

A neuron array drives the spike vectors and marks each timestep with a one-cycle strobe. Control logic writes the shared sensitivity and can load a full set of starting weights. The array presents the current weights and a one-cycle flip marker for each synapse.

Top module: `coin_syn_array`

## Requirements
- R1: While reset is low, and on its release, every weight reads 0, every toggle output reads 0 and the sensitivity is 0.
- R2: `load_i` high at a clock edge copies `load_w_i` to `weight_o` and clears every counter. It takes priority over a strobe at the same edge, and no toggle is reported for that edge.
- R3: At a strobed edge, a synapse counts one coincidence only when its `pre_spk_i` bit and its `post_spk_i` bit are both 1. A spike on one side alone adds nothing.
- R4: When a synapse's count after the increment is at least the sensitivity, its weight inverts at that edge and its counter returns to 0. The next flip therefore needs another full set of coincidences.
- R5: `toggle_o[i]` is 1 for exactly the one cycle in which `weight_o[i]` shows a newly inverted value. It is 0 at all other times.
- R6: A flip happens the same way from 0 to 1 and from 1 to 0, after the same number of coincidences.
- R7: A sensitivity of 0 disables the array. No counter advances and no weight flips at any strobe.
- R8: With `step_i` low, spikes have no effect. Weights, toggles and counters all hold.
- R9: A sensitivity write (`sens_wr_i`, 4-bit `sens_data_i`) applies to strobes after the write edge. A strobe at the same edge still uses the old value. If the sensitivity is lowered to or below a synapse's stored count, that synapse flips on its next coincidence.
- R10: Each synapse counts and flips on its own bit positions only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Timestep strobe |
| pre_spk_i | input | N_SYN | Presynaptic spikes, one per synapse |
| post_spk_i | input | N_SYN | Postsynaptic spikes, one per synapse |
| sens_wr_i | input | 1 | Sensitivity write enable |
| sens_data_i | input | SENS_W | Sensitivity value to write |
| load_i | input | 1 | Load starting weights and clear counters |
| load_w_i | input | N_SYN | Starting weights |
| weight_o | output | N_SYN | Current weights |
| toggle_o | output | N_SYN | One-cycle flip marker per synapse |

## Verification
Two pairs of functions can meet at one edge: a load with a coincidence strobe, and a sensitivity write with a strobe. The bench raises both signals on the same cycle, partway through a count. It judges a load collision by checking that the loaded weights appear with no toggle and that the next flip needs the full coincidence count again. It judges a write collision by checking that the strobe was counted against the old sensitivity. A behavioural model that runs alongside the design checks both cases on every clock.

// File: rtl/syn_pkg.sv
package syn_pkg;
  function automatic logic [7:0] bump_count(input logic [7:0] cnt, input logic coinc);
    return coinc ? cnt + 8'd1 : cnt;
  endfunction

  function automatic logic count_reached(input logic [7:0] cnt_next, input logic [7:0] sens);
    return (sens != 8'd0) && (cnt_next >= sens);
  endfunction
endpackage

// File: rtl/syn_sens_reg.sv
module syn_sens_reg #(
  parameter int SENS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [SENS_W-1:0] data_i,
  output logic [SENS_W-1:0] sens_o,
  output logic              enable_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sens_o <= '0;
    else if (wr_i) sens_o <= data_i;
  end

  assign enable_o = (sens_o != '0);

  // R9: sensitivity changes only through a write
  a_r9_sens_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_i) |-> $stable(sens_o));
endmodule

// File: rtl/syn_cell.sv
module syn_cell
  import syn_pkg::*;
#(
  parameter int SENS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              pre_i,
  input  logic              post_i,
  input  logic              load_i,
  input  logic              load_w_i,
  input  logic [SENS_W-1:0] sens_i,
  input  logic              enable_i,
  output logic              weight_o,
  output logic              toggle_o
);
  localparam int CNT_W = SENS_W;

  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       cnt_wide;
  logic             hit_evt;
  logic             flip_evt;

  assign hit_evt  = step_i && enable_i && pre_i && post_i;
  assign cnt_wide = bump_count(8'(cnt_q), hit_evt);
  assign flip_evt = hit_evt && count_reached(cnt_wide, 8'(sens_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      weight_o <= 1'b0;
      toggle_o <= 1'b0;
    end else if (load_i) begin
      cnt_q    <= '0;
      weight_o <= load_w_i;
      toggle_o <= 1'b0;
    end else begin
      toggle_o <= flip_evt;
      if (flip_evt) begin
        cnt_q    <= '0;
        weight_o <= ~weight_o;
      end else if (hit_evt) begin
        cnt_q    <= cnt_wide[CNT_W-1:0];
      end
    end
  end

  a_r5_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_o |-> (weight_o != $past(weight_o)));
  a_r4_clear_on_flip: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_o |-> (cnt_q == '0));
  a_r8_hold_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(step_i) && !$past(load_i)) |-> ($stable(weight_o) && !toggle_o));
  a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sens_i) == '0 && !$past(load_i)) |-> (!toggle_o && $stable(cnt_q)));
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_i) |-> (weight_o == $past(load_w_i) && cnt_q == '0 && !toggle_o));
endmodule

// File: rtl/coin_syn_array.sv
module coin_syn_array #(
  parameter int N_SYN  = 8,
  parameter int SENS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic [N_SYN-1:0]  pre_spk_i,
  input  logic [N_SYN-1:0]  post_spk_i,
  input  logic              sens_wr_i,
  input  logic [SENS_W-1:0] sens_data_i,
  input  logic              load_i,
  input  logic [N_SYN-1:0]  load_w_i,
  output logic [N_SYN-1:0]  weight_o,
  output logic [N_SYN-1:0]  toggle_o
);
  logic [SENS_W-1:0] sens_q;
  logic              enable_w;

  syn_sens_reg #(.SENS_W(SENS_W)) u_sens (
    .clk(clk), .rst_n(rst_n), .wr_i(sens_wr_i), .data_i(sens_data_i),
    .sens_o(sens_q), .enable_o(enable_w)
  );

  for (genvar i = 0; i < N_SYN; i++) begin : g_syn
    syn_cell #(.SENS_W(SENS_W)) u_cell (
      .clk(clk), .rst_n(rst_n), .step_i(step_i),
      .pre_i(pre_spk_i[i]), .post_i(post_spk_i[i]),
      .load_i(load_i), .load_w_i(load_w_i[i]),
      .sens_i(sens_q), .enable_i(enable_w),
      .weight_o(weight_o[i]), .toggle_o(toggle_o[i])
    );
  end

  // R1: nothing flips straight out of reset
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (toggle_o == '0));
endmodule

// File: tb/tb_coin_syn_array.sv
module tb_coin_syn_array;
  localparam int N = 8;

  logic clk = 0, rst_n = 0, step = 0, sens_wr = 0, load = 0;
  logic [N-1:0] pre = '0, post = '0, load_w = '0;
  logic [3:0] sens_data = '0;
  logic [N-1:0] weight, toggle;

  always #10 clk = ~clk;

  coin_syn_array #(.N_SYN(N), .SENS_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .step_i(step), .pre_spk_i(pre), .post_spk_i(post),
    .sens_wr_i(sens_wr), .sens_data_i(sens_data), .load_i(load), .load_w_i(load_w),
    .weight_o(weight), .toggle_o(toggle)
  );

  int m_cnt[N];
  bit m_w[N];
  bit m_t[N];
  int m_sens = 0;
  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sens = 0;
      for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_w[i] = 0; m_t[i] = 0; end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (load) begin
          m_w[i] = load_w[i]; m_cnt[i] = 0; m_t[i] = 0;
        end else begin
          m_t[i] = 0;
          if (step && m_sens != 0 && pre[i] && post[i]) begin
            m_cnt[i] = m_cnt[i] + 1;
            if (m_cnt[i] >= m_sens) begin
              m_w[i] = !m_w[i]; m_cnt[i] = 0; m_t[i] = 1;
            end
          end
        end
      end
      if (sens_wr) m_sens = sens_data;
    end
  end

  always @(negedge clk) begin
    cycles++;
    for (int i = 0; i < N; i++) begin
      checks++;
      if (weight[i] !== m_w[i] || toggle[i] !== m_t[i]) begin
        fails++;
        $display("FAIL %s syn%0d: weight=%b toggle=%b expected weight=%b toggle=%b",
                 cur_req, i, weight[i], toggle[i], m_w[i], m_t[i]);
      end
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic tick(input bit s, input logic [N-1:0] p, input logic [N-1:0] q);
    step = s; pre = p; post = q;
    @(negedge clk);
    step = 0; pre = '0; post = '0; sens_wr = 0; load = 0;
  endtask

  task automatic write_sens(input int v);
    sens_wr = 1; sens_data = 4'(v);
    tick(0, '0, '0);
  endtask

  initial begin
    // R1: reset state observed by the per-cycle compare
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R7: sensitivity 0, coincidences do nothing
    cur_req = "R7";
    for (int k = 0; k < 20; k++) tick(1, '1, '1);

    // R9: write and strobe together, strobe uses old sensitivity 0
    cur_req = "R9";
    sens_wr = 1; sens_data = 4'd3;
    tick(1, 8'h01, 8'h01);

    // R8: spikes without strobe ignored
    cur_req = "R8";
    for (int k = 0; k < 10; k++) tick(0, '1, '1);

    // R3: one-sided spikes do not count; R4/R5 flip after 3 coincidences
    cur_req = "R3";
    tick(1, 8'h01, 8'h00);
    tick(1, 8'h00, 8'h01);
    tick(1, 8'h01, 8'h02);
    cur_req = "R4";
    for (int k = 0; k < 3; k++) tick(1, 8'h01, 8'h01);
    tick(0, '0, '0);
    // R6: flip back 1 -> 0 after the same count
    cur_req = "R6";
    for (int k = 0; k < 3; k++) tick(1, 8'h01, 8'h01);

    // R10: independent synapses under mixed patterns
    cur_req = "R10";
    for (int k = 0; k < 300; k++) tick($urandom_range(0, 1), N'($urandom), N'($urandom));

    // R2: load collides with strobe mid-count
    cur_req = "R2";
    tick(1, '1, '1);
    load = 1; load_w = 8'hA5;
    tick(1, '1, '1);
    for (int k = 0; k < 4; k++) tick(1, '1, '1);

    // R9: lower sensitivity below a stored count
    cur_req = "R9";
    write_sens(9);
    load = 1; load_w = 8'h0F; tick(0, '0, '0);
    for (int k = 0; k < 6; k++) tick(1, '1, '1);
    write_sens(2);
    tick(1, '1, '1);
    tick(1, '1, '1);
    write_sens(15);
    for (int k = 0; k < 40; k++) tick(1, '1, '1);

    // R5/R10: long mixed run with sensitivity changes
    cur_req = "R5";
    for (int k = 0; k < 400; k++) begin
      if (k % 97 == 0) begin sens_wr = 1; sens_data = 4'($urandom_range(0, 15)); end
      if (k % 151 == 0) begin load = 1; load_w = N'($urandom); end
      tick($urandom_range(0, 3) != 0, N'($urandom), N'($urandom));
    end

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule